// File: doc/BRIEF.md
# Memory-Mapped Data Memory Decoder

This block is the data side of a small 16-bit single-cycle processor. One address port serves three regions: a general-purpose RAM at the bottom of the map, a screen buffer directly above it, and one keyboard word directly above the screen. The decoder looks at the address, sends the write strobe only to the region the address falls in, and returns that region's word on the read bus. The keyboard word is not stored here: it mirrors the `key_code` input and cannot be written. The screen buffer is ordinary storage that the processor can also read back. Display scan-out is handled elsewhere.

Region sizes are parameters. With `RAM_AW = 15` and `SCR_AW = 13` the map has RAM at 0 to 32767, the screen at 32768 to 40959 and the keyboard at 40960. The defaults (`RAM_AW = 10`, `SCR_AW = 8`) keep elaboration small: RAM 0 to 1023, screen 1024 to 1279, keyboard 1280. The port has no valid/ready handshake and never applies back-pressure. It is always ready, a write completes at the clock edge in which `mem_we` is high, and a read is valid in the same cycle as its address.

Top module: `mdm_top`

## Requirements
- R1: Addresses 0 to 2^RAM_AW-1 select the RAM. A word written there is returned by a later read of the same address.
- R2: The 2^SCR_AW addresses that follow the RAM select the screen buffer. A word written there is returned by a later read of the same address.
- R3: A read of address 2^RAM_AW+2^SCR_AW (1280 by default) returns the current `key_code`. A change of `key_code` shows on `mem_rdata` in the same cycle.
- R4: A write to the keyboard address has no effect. It changes neither the keyboard read value nor any RAM or screen word.
- R5: Reads of addresses above the keyboard address return 0. Writes to those addresses change no RAM or screen word.
- R6: A write reaches only the region it addresses. A RAM write leaves the screen word at the same offset unchanged, and a screen write leaves the RAM word at the same offset unchanged.
- R7: A write takes effect at the rising clock edge. Before that edge `mem_rdata` shows the old word. After the edge it shows the new word, with no extra read cycle.
- R8: While `rst_n` is low, `mem_we` is ignored and no word changes.
- R9: With `mem_we` low, the value on `mem_wdata` changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| mem_addr | input | AW (16) | Word address |
| mem_wdata | input | DW (16) | Write data |
| mem_we | input | 1 | Write strobe for the addressed word |
| key_code | input | DW (16) | Live keyboard value, returned at the keyboard address |
| mem_rdata | output | DW (16) | Combinational read data for `mem_addr` |

## Verification
Writes and reads are driven at the first and last word of each region and at the keyboard address. The same offset is written in RAM and in the screen to separate correct steering from aliasing caused by dropped upper address bits. Writes to the keyboard address, to the word just above it and to 0xFFFF are chosen so that their low bits collide with known RAM and screen words. Any leaked write would therefore corrupt a word that the bench reads back. A single write is sampled before and after its clock edge to confirm that the write is edge-timed and the read is combinational, and writes issued with reset low or with the strobe low show that both guards hold.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_SCR  = 2'd1,
    RGN_KEY  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/mdm_decode.sv
module mdm_decode #(
  parameter int AW     = 16,
  parameter int RAM_AW = 10,
  parameter int SCR_AW = 8
) (
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 we,
  output mdm_pkg::region_e     region,
  output logic                 ram_we,
  output logic                 scr_we,
  output logic [RAM_AW-1:0]    ram_idx,
  output logic [SCR_AW-1:0]    scr_idx
);
  localparam logic [AW:0] RAM_END = (AW+1)'(1) << RAM_AW;
  localparam logic [AW:0] SCR_END = RAM_END + ((AW+1)'(1) << SCR_AW);

  logic [AW:0] addr_x;
  assign addr_x = {1'b0, addr};

  always_comb begin
    if (addr_x < RAM_END)       region = mdm_pkg::RGN_RAM;
    else if (addr_x < SCR_END)  region = mdm_pkg::RGN_SCR;
    else if (addr_x == SCR_END) region = mdm_pkg::RGN_KEY;
    else                        region = mdm_pkg::RGN_NONE;
  end

  // The screen base is a multiple of the screen size (RAM_AW >= SCR_AW),
  // so the low address bits are already the screen offset.
  assign ram_idx = addr[RAM_AW-1:0];
  assign scr_idx = addr[SCR_AW-1:0];

  assign ram_we = we && rst_n && (region == mdm_pkg::RGN_RAM);
  assign scr_we = we && rst_n && (region == mdm_pkg::RGN_SCR);
endmodule

// File: rtl/mdm_store.sv
module mdm_store #(
  parameter int DW = 16,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[idx] <= wdata;
  end

  assign rdata = words[idx];

  // R1 / R2: a strobed write is present in storage one edge later
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> words[$past(idx)] == $past(wdata));

  // R9: without a strobe the addressed word keeps its value
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> words[$past(idx)] == $past(words[idx]));
endmodule

// File: rtl/mdm_top.sv
module mdm_top #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int RAM_AW = 10,
  parameter int SCR_AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  input  logic          mem_we,
  input  logic [DW-1:0] key_code,
  output logic [DW-1:0] mem_rdata
);
  localparam logic [AW:0] KEY_ADDR = ((AW+1)'(1) << RAM_AW) + ((AW+1)'(1) << SCR_AW);

  mdm_pkg::region_e    region;
  logic                ram_we, scr_we;
  logic [RAM_AW-1:0]   ram_idx;
  logic [SCR_AW-1:0]   scr_idx;
  logic [DW-1:0]       ram_rd, scr_rd;

  mdm_decode #(.AW(AW), .RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) u_dec (
    .rst_n   (rst_n),
    .addr    (mem_addr),
    .we      (mem_we),
    .region  (region),
    .ram_we  (ram_we),
    .scr_we  (scr_we),
    .ram_idx (ram_idx),
    .scr_idx (scr_idx)
  );

  mdm_store #(.DW(DW), .IW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .idx   (ram_idx),
    .wdata (mem_wdata),
    .rdata (ram_rd)
  );

  mdm_store #(.DW(DW), .IW(SCR_AW)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (scr_we),
    .idx   (scr_idx),
    .wdata (mem_wdata),
    .rdata (scr_rd)
  );

  always_comb begin
    unique case (region)
      mdm_pkg::RGN_RAM: mem_rdata = ram_rd;
      mdm_pkg::RGN_SCR: mem_rdata = scr_rd;
      mdm_pkg::RGN_KEY: mem_rdata = key_code;
      default:          mem_rdata = '0;
    endcase
  end

  // R6: at most one region receives the strobe
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, scr_we}));

  // R3: the keyboard address mirrors the live input
  assert_key_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, mem_addr} == KEY_ADDR) |-> (mem_rdata == key_code));

  // R4 / R5: the keyboard word and the space above it never store anything
  assert_no_store_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, mem_addr} >= KEY_ADDR) |-> !(ram_we || scr_we));

  // R5: the space above the keyboard reads as zero
  assert_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, mem_addr} > KEY_ADDR) |-> (mem_rdata == '0));
endmodule

// File: tb/sim_mdm_top.sv
module sim_mdm_top;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [15:0] mem_wdata = '0;
  logic        mem_we = 1'b0;
  logic [15:0] key_code = '0;
  logic [15:0] mem_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [15:0] SCR0 = 16'd1024;
  localparam logic [15:0] SCRL = 16'd1279;
  localparam logic [15:0] KEYA = 16'd1280;

  always #(HALF) clk = ~clk;

  mdm_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .key_code  (key_code),
    .mem_rdata (mem_rdata)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_addr = a; mem_wdata = d; mem_we = 1'b1;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    @(negedge clk);
    mem_addr = a;
    #1;
    check(tag, mem_rdata, exp);
  endtask

  task automatic t_reset_state;
    key_code = 16'h1234;
    rd_chk("reset R3 key read", KEYA, 16'h1234);
    rd_chk("reset R5 high read", 16'hFFFF, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_ram;
    wr(16'd0, 16'hA5A5);
    wr(16'd1023, 16'h5A5A);
    wr(16'd3, 16'h0003);
    rd_chk("R1 ram first", 16'd0, 16'hA5A5);
    rd_chk("R1 ram last", 16'd1023, 16'h5A5A);
    rd_chk("R1 ram mid", 16'd3, 16'h0003);
  endtask

  task automatic t_screen;
    wr(SCR0, 16'h1111);
    wr(SCRL, 16'h2222);
    rd_chk("R2 screen first", SCR0, 16'h1111);
    rd_chk("R2 screen last", SCRL, 16'h2222);
  endtask

  task automatic t_steer;
    rd_chk("R6 ram0 after screen write", 16'd0, 16'hA5A5);
    wr(16'd0, 16'h7777);
    rd_chk("R6 screen0 after ram write", SCR0, 16'h1111);
    rd_chk("R6 ram0 new value", 16'd0, 16'h7777);
  endtask

  task automatic t_key_live;
    @(negedge clk);
    mem_addr = KEYA; key_code = 16'hBEEF;
    #1 check("R3 key value A", mem_rdata, 16'hBEEF);
    key_code = 16'h0042;
    #0.5 check("R3 key same-cycle change", mem_rdata, 16'h0042);
  endtask

  task automatic t_key_write;
    wr(16'd256, 16'h0256);
    wr(16'd257, 16'h0257);
    wr(16'd1025, 16'h1025);
    key_code = 16'h00AA;
    wr(KEYA, 16'hFFFF);
    rd_chk("R4 key unchanged", KEYA, 16'h00AA);
    rd_chk("R4 ram alias intact", 16'd256, 16'h0256);
    rd_chk("R4 screen alias intact", SCR0, 16'h1111);
  endtask

  task automatic t_high;
    wr(16'd1281, 16'hDEAD);
    wr(16'hFFFF, 16'hDEAD);
    rd_chk("R5 read above key", 16'd1281, 16'h0000);
    rd_chk("R5 read top", 16'hFFFF, 16'h0000);
    rd_chk("R5 ram alias 257", 16'd257, 16'h0257);
    rd_chk("R5 ram alias 1023", 16'd1023, 16'h5A5A);
    rd_chk("R5 screen alias 1", 16'd1025, 16'h1025);
    rd_chk("R5 screen alias last", SCRL, 16'h2222);
  endtask

  task automatic t_edge;
    @(negedge clk);
    mem_addr = 16'd3; mem_wdata = 16'h4321; mem_we = 1'b1;
    #1 check("R7 old value before edge", mem_rdata, 16'h0003);
    @(posedge clk);
    #1 check("R7 new value after edge", mem_rdata, 16'h4321);
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    mem_addr = 16'd3; mem_wdata = 16'hFACE; mem_we = 1'b0;
    repeat (2) @(negedge clk);
    #1 check("R9 no strobe no change", mem_rdata, 16'h4321);
    @(negedge clk);
    mem_addr = SCR0;
    repeat (2) @(negedge clk);
    #1 check("R9 screen no strobe", mem_rdata, 16'h1111);
  endtask

  task automatic t_reset_guard;
    @(negedge clk);
    rst_n = 1'b0;
    wr(16'd3, 16'h0BAD);
    wr(SCR0, 16'h0BAD);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R8 ram held in reset", 16'd3, 16'h4321);
    rd_chk("R8 screen held in reset", SCR0, 16'h1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ram();
    t_screen();
    t_steer();
    t_key_live();
    t_key_write();
    t_high();
    t_edge();
    t_idle();
    t_reset_guard();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule